// File: doc/BRIEF.md
# Single-Wire Return-to-One Slave Controller

This block is the slave end of an asynchronous single-wire serial bus. The wire is open-drain: every party can only pull it low or let it float high. Bits are sent as return-to-one cells. Each cell begins with a falling edge, and the length of the low phase carries the bit value. A long low pulse, called a break, resets the framing. Once the line has been high again for a recovery time, the block accepts a command byte.

The command byte holds a register address and a direction flag. On a write, the block stores either one received byte, or two received bytes into consecutive addresses, through a simple register-file port. On a read, it waits a turnaround time. It then drives one byte from the addressed register onto the wire by pulling the line low for short or long pulses.

All timing is given in clock cycles through parameters. The line input is taken in through a two-flop synchroniser.

Top module: `sw_rz_slave`

## Requirements
- R1: After reset the line is released, no register write occurs, and bit cells are ignored until the first break and its recovery have completed.
- R2: Each received bit is decoded from the synchronised line at the rising edge that ends its low phase. A low phase shorter than BIT_THRESH cycles decodes as 1. A longer low phase decodes as 0.
- R3: All bytes travel least significant bit first. In the command byte, bits 6..0 form the register address and bit 7 is the direction flag, where 1 means write and 0 means read. Any register that no command targets keeps its content.
- R4: After a write command, eight data bits followed by WR_IDLE cycles of high line cause exactly one write of that byte to the addressed register.
- R5: After a write command, sixteen data bits cause a write of the first byte to the addressed register. On the following cycle the second byte is written to the address plus one, modulo 128.
- R6: A read response sends the addressed register's byte in eight cells of TX_CELL cycles each. In each cell the line is pulled low for TX_SHORT cycles for a 1 or TX_LONG cycles for a 0, and then released.
- R7: The first pull of a read response comes exactly TURN_CYC + 3 cycles after the host releases the line at the end of the last command bit.
- R8: A low phase of at least BREAK_MIN cycles abandons any command, data or response in progress, and no partial byte or word is written. The block is ready again once the line has stayed high for RECOV_CYC cycles.
- R9: The block only ever asserts a pull-low enable, and only while it is sending a read response.
- R10: After a completed write or read, the block accepts the next command without a new break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Bus wire level (asynchronous) |
| pull_o | output | 1 | Open-drain enable: 1 pulls the wire low |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_addr_o | output | 7 | Register-file address for read and write |
| rf_wdata_o | output | 8 | Register-file write data |
| rf_rdata_i | input | 8 | Register-file read data, combinational from rf_addr_o |

## Verification
Several rules are checked by assertions on every cycle:
- A decoded bit only appears on a synchronised rising edge.
- A break only fires after sustained low.
- A break suppresses any write on the next cycle.
- The two writes of a word go to consecutive addresses.
- A response never starts while the transmitter is busy or while the line is low.
- The pull enable appears only in the sending state.

Other behaviour only shows up in the bench scenarios. These cover the decoded values and their bit order, the idle timeout that commits a single byte, the discard of partial bytes and words on a break, the exact turnaround and cell timing seen on the wire, the address wrap, and back-to-back commands without a break.

// File: rtl/sw_rz_pkg.sv
package sw_rz_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_WAIT_BRK,
    ST_CMD,
    ST_DATA,
    ST_TURN,
    ST_SEND,
    ST_WRITE
  } ctrl_st_e;
endpackage

// File: rtl/sw_rz_rx.sv
module sw_rz_rx #(
  parameter int BREAK_MIN  = 64,
  parameter int RECOV_CYC  = 16,
  parameter int BIT_THRESH = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_hi_o,
  output logic bit_vld_o,
  output logic bit_o,
  output logic brk_o,
  output logic ready_o
);
  localparam int LOW_W = $clog2(BREAK_MIN + 1);
  localparam int HI_W  = $clog2(RECOV_CYC + 1);
  localparam logic [LOW_W-1:0] LOW_SAT  = LOW_W'(BREAK_MIN);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(BREAK_MIN - 1);
  localparam logic [LOW_W-1:0] THR_C    = LOW_W'(BIT_THRESH);
  localparam logic [HI_W-1:0]  HI_LAST  = HI_W'(RECOV_CYC - 1);

  logic [1:0]       sync_q;
  logic             line_s;
  logic [LOW_W-1:0] low_cnt_q;
  logic [HI_W-1:0]  hi_cnt_q;
  logic             in_brk_q;

  assign line_s    = sync_q[1];
  assign line_hi_o = line_s;
  assign brk_o     = !line_s && (low_cnt_q == LOW_LAST);
  assign ready_o   = in_brk_q && line_s && (hi_cnt_q == HI_LAST);
  // low_cnt_q still holds the length of the low phase that just ended
  assign bit_vld_o = line_s && (low_cnt_q != '0) && !in_brk_q;
  assign bit_o     = low_cnt_q < THR_C;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 2'b11;
      low_cnt_q <= '0;
      hi_cnt_q  <= '0;
      in_brk_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (!line_s) begin
        if (low_cnt_q != LOW_SAT) low_cnt_q <= low_cnt_q + 1'b1;
      end else begin
        low_cnt_q <= '0;
      end
      if (in_brk_q && line_s) hi_cnt_q <= hi_cnt_q + 1'b1;
      else                    hi_cnt_q <= '0;
      if (brk_o)        in_brk_q <= 1'b1;
      else if (ready_o) in_brk_q <= 1'b0;
    end
  end

  p_bit_on_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |-> line_s && !$past(line_s));
  p_brk_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> !line_s && !$past(line_s));
endmodule

// File: rtl/sw_rz_tx.sv
module sw_rz_tx #(
  parameter int TX_SHORT = 8,
  parameter int TX_LONG  = 32,
  parameter int TX_CELL  = 48
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       abort_i,
  output logic       pull_o,
  output logic       done_o
);
  localparam int CW = $clog2(TX_CELL);
  localparam logic [CW-1:0] SHORT_C = CW'(TX_SHORT);
  localparam logic [CW-1:0] LONG_C  = CW'(TX_LONG);
  localparam logic [CW-1:0] LAST_C  = CW'(TX_CELL - 1);

  logic [7:0]    sh_q;
  logic [2:0]    idx_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  assign pull_o = busy_q && (cnt_q < (sh_q[0] ? SHORT_C : LONG_C));
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        sh_q   <= byte_i;
        idx_q  <= '0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == LAST_C) begin
          cnt_q <= '0;
          sh_q  <= {1'b0, sh_q[7:1]};
          if (idx_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_start_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/sw_rz_ctrl.sv
module sw_rz_ctrl
  import sw_rz_pkg::*;
#(
  parameter int TURN_CYC = 20,
  parameter int WR_IDLE  = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              brk_i,
  input  logic              ready_i,
  input  logic              line_hi_i,
  input  logic              tx_done_i,
  output logic              tx_start_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              sending_o,
  output logic              rf_we_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  input  logic [DATA_W-1:0] rf_rdata_i
);
  localparam int TMAX = (TURN_CYC > WR_IDLE) ? TURN_CYC : WR_IDLE;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] TURN_LAST = TW'(TURN_CYC - 1);
  localparam logic [TW-1:0] IDLE_LAST = TW'(WR_IDLE - 1);

  ctrl_st_e            st_q;
  logic [4:0]          nbits_q;
  logic [15:0]         sr_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wd_q;
  logic [DATA_W-1:0]   hi_q;
  logic                two_q;
  logic [TW-1:0]       tmr_q;

  assign tx_start_o = (st_q == ST_TURN) && (tmr_q == TURN_LAST);
  assign tx_byte_o  = rf_rdata_i;
  assign sending_o  = (st_q == ST_SEND);
  assign rf_we_o    = (st_q == ST_WRITE);
  assign rf_addr_o  = addr_q;
  assign rf_wdata_o = wd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_WAIT_BRK;
      nbits_q <= '0;
      sr_q    <= '0;
      addr_q  <= '0;
      wd_q    <= '0;
      hi_q    <= '0;
      two_q   <= 1'b0;
      tmr_q   <= '0;
    end else if (brk_i) begin
      st_q    <= ST_WAIT_BRK;
      nbits_q <= '0;
      two_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_WAIT_BRK: begin
          if (ready_i) begin
            st_q    <= ST_CMD;
            nbits_q <= '0;
          end
        end
        ST_CMD: begin
          if (bit_vld_i) begin
            sr_q    <= {bit_i, sr_q[15:1]};
            nbits_q <= nbits_q + 1'b1;
            if (nbits_q == 5'd7) begin
              addr_q  <= sr_q[15:9];
              nbits_q <= '0;
              tmr_q   <= '0;
              st_q    <= bit_i ? ST_DATA : ST_TURN;
            end
          end
        end
        ST_DATA: begin
          if (bit_vld_i) begin
            sr_q    <= {bit_i, sr_q[15:1]};
            nbits_q <= nbits_q + 1'b1;
            tmr_q   <= '0;
            if (nbits_q == 5'd15) begin
              wd_q  <= sr_q[8:1];
              hi_q  <= {bit_i, sr_q[15:9]};
              two_q <= 1'b1;
              st_q  <= ST_WRITE;
            end
          end else if (nbits_q == 5'd8) begin
            // single byte commits once the line has idled long enough
            if (!line_hi_i) begin
              tmr_q <= '0;
            end else if (tmr_q == IDLE_LAST) begin
              wd_q  <= sr_q[15:8];
              two_q <= 1'b0;
              st_q  <= ST_WRITE;
            end else begin
              tmr_q <= tmr_q + 1'b1;
            end
          end
        end
        ST_TURN: begin
          tmr_q <= tmr_q + 1'b1;
          if (tmr_q == TURN_LAST) st_q <= ST_SEND;
        end
        ST_SEND: begin
          if (tx_done_i) begin
            st_q    <= ST_CMD;
            nbits_q <= '0;
          end
        end
        ST_WRITE: begin
          if (two_q) begin
            addr_q <= addr_q + 1'b1;
            wd_q   <= hi_q;
            two_q  <= 1'b0;
          end else begin
            st_q    <= ST_CMD;
            nbits_q <= '0;
          end
        end
        default: st_q <= ST_WAIT_BRK;
      endcase
    end
  end

  p_brk_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> !rf_we_o && (st_q == ST_WAIT_BRK));
  p_wr_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && two_q && !brk_i) |=> rf_we_o && (rf_addr_o == $past(rf_addr_o) + 7'd1));
endmodule

// File: rtl/sw_rz_slave.sv
module sw_rz_slave
  import sw_rz_pkg::*;
#(
  parameter int BREAK_MIN  = 64,
  parameter int RECOV_CYC  = 16,
  parameter int BIT_THRESH = 20,
  parameter int TX_SHORT   = 8,
  parameter int TX_LONG    = 32,
  parameter int TX_CELL    = 48,
  parameter int TURN_CYC   = 20,
  parameter int WR_IDLE    = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic              pull_o,
  output logic              rf_we_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  input  logic [DATA_W-1:0] rf_rdata_i
);
  logic line_hi, bit_vld, bit_val, brk, ready;
  logic tx_start, tx_done, sending;
  logic [DATA_W-1:0] tx_byte;

  sw_rz_rx #(
    .BREAK_MIN (BREAK_MIN),
    .RECOV_CYC (RECOV_CYC),
    .BIT_THRESH(BIT_THRESH)
  ) rx_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line_i),
    .line_hi_o(line_hi),
    .bit_vld_o(bit_vld),
    .bit_o    (bit_val),
    .brk_o    (brk),
    .ready_o  (ready)
  );

  sw_rz_ctrl #(
    .TURN_CYC(TURN_CYC),
    .WR_IDLE (WR_IDLE)
  ) ctrl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_vld_i (bit_vld),
    .bit_i     (bit_val),
    .brk_i     (brk),
    .ready_i   (ready),
    .line_hi_i (line_hi),
    .tx_done_i (tx_done),
    .tx_start_o(tx_start),
    .tx_byte_o (tx_byte),
    .sending_o (sending),
    .rf_we_o   (rf_we_o),
    .rf_addr_o (rf_addr_o),
    .rf_wdata_o(rf_wdata_o),
    .rf_rdata_i(rf_rdata_i)
  );

  sw_rz_tx #(
    .TX_SHORT(TX_SHORT),
    .TX_LONG (TX_LONG),
    .TX_CELL (TX_CELL)
  ) tx_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tx_start),
    .byte_i (tx_byte),
    .abort_i(brk),
    .pull_o (pull_o),
    .done_o (tx_done)
  );

  p_pull_in_send_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_o |-> sending);
  p_start_line_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start |-> line_hi);
endmodule

// File: tb/sw_rz_slave_tb.sv
`timescale 1ns/1ps
module sw_rz_slave_tb_top;
  localparam int THR  = 20;
  localparam int SH   = 8;
  localparam int LG   = 32;
  localparam int CELL = 48;
  localparam int TURN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_pull = 1'b0;
  logic dut_pull;
  logic line;
  logic rf_we;
  logic [6:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata;
  logic [7:0] mem [128];
  logic [7:0] exp_m [128];
  int n_cmp = 0, n_bad = 0, pull_stray = 0;
  bit in_read = 1'b0;

  always #2.5 clk = ~clk;
  assign line = !(host_pull || dut_pull);
  assign rf_rdata = mem[rf_addr];

  sw_rz_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .pull_o(dut_pull),
    .rf_we_o(rf_we), .rf_addr_o(rf_addr), .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata)
  );

  always @(posedge clk) if (rf_we) mem[rf_addr] <= rf_wdata;
  always @(negedge clk) if (dut_pull && !in_read) pull_stray++;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic send_break();
    @(negedge clk); host_pull = 1'b1;
    repeat (80) @(negedge clk);
    host_pull = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    host_pull = 1'b1;
    repeat (b ? SH : LG) @(negedge clk);
    host_pull = 1'b0;
    repeat (b ? CELL - SH : CELL - LG) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic do_write8(input logic [6:0] a, input logic [7:0] d, input bit brk);
    if (brk) send_break();
    send_byte({1'b1, a});
    send_byte(d);
    repeat (130) @(negedge clk);
    exp_m[a] = d;
    chk(mem[a] == exp_m[a], "R4 byte write", mem[a], exp_m[a]);
  endtask

  task automatic do_write16(input logic [6:0] a, input logic [15:0] w, input bit brk);
    logic [6:0] a1;
    a1 = a + 7'd1;
    if (brk) send_break();
    send_byte({1'b1, a});
    send_byte(w[7:0]);
    send_byte(w[15:8]);
    repeat (20) @(negedge clk);
    exp_m[a]  = w[7:0];
    exp_m[a1] = w[15:8];
    chk(mem[a]  == exp_m[a],  "R5 word low byte",  mem[a],  exp_m[a]);
    chk(mem[a1] == exp_m[a1], "R5 word high byte", mem[a1], exp_m[a1]);
  endtask

  task automatic do_read(input logic [6:0] a, input bit brk);
    logic [7:0] got, want;
    int turn, lo, hi;
    want = exp_m[a];
    got = '0;
    if (brk) send_break();
    for (int i = 0; i < 7; i++) send_bit(a[i]);
    host_pull = 1'b1;
    repeat (LG) @(negedge clk);
    host_pull = 1'b0;
    in_read = 1'b1;
    turn = 0;
    while (turn < 400) begin
      @(negedge clk); turn++;
      if (!line) break;
    end
    chk(turn == TURN + 3, "R7 turnaround", turn, TURN + 3);
    for (int i = 0; i < 8; i++) begin
      lo = 0;
      while (!line && lo < 200) begin @(negedge clk); lo++; end
      got[i] = (lo < THR);
      chk(lo == (want[i] ? SH : LG), "R6 pulse length", lo, want[i] ? SH : LG);
      if (i < 7) begin
        hi = 0;
        while (line && hi < 200) begin @(negedge clk); hi++; end
        chk(lo + hi == CELL, "R6 cell length", lo + hi, CELL);
      end
    end
    repeat (50) @(negedge clk);
    in_read = 1'b0;
    chk(got == want, "R3 read value", got, want);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    int dummy, bad_cells;
    logic [6:0] a;
    dummy = $urandom(32'h0005_eed1);
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'($urandom);
      exp_m[i] = mem[i];
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dut_pull == 1'b0, "R1 reset pull", dut_pull, 0);
    chk(rf_we == 1'b0, "R1 reset write", rf_we, 0);

    // R1: traffic before any break must be ignored
    send_byte({1'b1, 7'h05});
    send_byte(8'hAA);
    send_byte(8'h55);
    repeat (130) @(negedge clk);
    chk(mem[5] == exp_m[5], "R1 no write before break", mem[5], exp_m[5]);
    chk(mem[6] == exp_m[6], "R1 no write before break", mem[6], exp_m[6]);

    do_write8(7'h10, 8'h3C, 1'b1);     // R2 mixed 1/0 cells
    do_read(7'h10, 1'b1);
    do_write16(7'h7F, 16'hBEEF, 1'b1); // R5 address wrap
    do_read(7'h7F, 1'b1);
    do_read(7'h00, 1'b1);
    do_write16(7'h40, 16'h1234, 1'b1);
    do_write8(7'h41, 8'h01, 1'b0);     // R10 no break between
    do_read(7'h41, 1'b0);              // R10

    // R8: break in the middle of a command
    send_break();
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    do_read(7'h10, 1'b1);

    // R8: break after 12 bits of a word
    send_break();
    send_byte({1'b1, 7'h20});
    send_byte(8'h77);
    for (int i = 0; i < 4; i++) send_bit(i[0]);
    send_break();
    repeat (20) @(negedge clk);
    chk(mem[7'h20] == exp_m[7'h20], "R8 partial word low", mem[7'h20], exp_m[7'h20]);
    chk(mem[7'h21] == exp_m[7'h21], "R8 partial word high", mem[7'h21], exp_m[7'h21]);

    // R8: break right after one data byte, before the idle timeout
    send_break();
    send_byte({1'b1, 7'h30});
    send_byte(8'h99);
    send_break();
    repeat (20) @(negedge clk);
    chk(mem[7'h30] == exp_m[7'h30], "R8 byte before idle", mem[7'h30], exp_m[7'h30]);

    for (int n = 0; n < 30; n++) begin
      a = 7'($urandom);
      case ($urandom_range(0, 2))
        0: do_write8(a, 8'($urandom), 1'b1);
        1: do_write16(a, 16'($urandom), 1'b1);
        default: do_read(a, 1'b1);
      endcase
    end

    bad_cells = 0;
    for (int i = 0; i < 128; i++) if (mem[i] !== exp_m[i]) bad_cells++;
    chk(bad_cells == 0, "R3 untouched registers", bad_cells, 0);
    chk(pull_stray == 0, "R9 pull outside response", pull_stray, 0);
    finish_run();
  end
endmodule